// File: doc/BRIEF.md
# Delay-Slot and Unit-Occupancy Scoreboard

This block sits beside the issue stage of a pipelined processor. It holds one countdown per architectural register and one per functional unit, and it times them separately. The register countdown says how many more cycles a result still needs before a later instruction may read it. The unit countdown says how many more cycles the unit stays occupied. Because the two are timed independently, a unit can take a new operation while its earlier result is still on the way.

Each cycle the issue stage presents one candidate instruction. The candidate carries an operation class, a target unit, two source registers and a destination register. The scoreboard answers in the same cycle:
- whether a source is still pending (data hazard);
- whether the unit is still occupied (resource conflict);
- whether the destination is still pending.

Stall is the OR of these three. A candidate that does not stall is issued at the next clock edge, and its latencies are loaded into the counters. Operand forwarding and the arithmetic itself are outside this block.

Top module: `sbScoreboard`

## Requirements
- R1: An active-low reset clears every register and unit countdown. After reset, no candidate sees a hazard, a conflict or a pending destination, even if operations were in flight when reset was applied.
- R2: Class code 0 is a single-cycle operation, and class code 3 is handled exactly like code 0. Both have zero delay slots and hold the unit only for the issue cycle. A following instruction may read the result, or use the unit, in the very next cycle.
- R3: Class code 1 (single-precision multiply or add) keeps its destination pending for the 3 cycles after issue. A reader of that register can issue in the 4th cycle after. The unit is free again in the cycle right after issue.
- R4: Class code 2 (double-precision multiply) keeps its unit occupied for the 3 cycles after the issue cycle. Any request to that unit in those cycles reports resConflict. The unit can be used again in the 4th cycle after issue.
- R5: Class code 2 keeps its destination pending for the 9 cycles after issue. A dependent class-2 operation can issue no earlier than the 10th cycle after the first.
- R6: A register index is 5 bits: bit 4 selects one of two register files, and bits 3..0 select one of its 16 registers. For class code 2, both sources and the destination name an even/odd pair {idx[4:1],0} and {idx[4:1],1}, and index bit 0 is ignored. An issued class-2 destination makes both halves pending.
- R7: The three checks are independent:
  - dataHazard reports a pending source;
  - resConflict reports an occupied unit;
  - destBusy reports a pending destination.

  Any combination of the three may be reported together.
- R8: stall is high exactly when issueReq is high and at least one of the three checks is reported. When issueReq is low, stall, dataHazard, resConflict, destBusy and issueAck are all low.
- R9: An operation is issued, and its countdowns loaded, only when issueReq is high and stall is low (issueAck high). A stalled request or an absent request changes no countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueReq | input | 1 | A candidate instruction is presented this cycle |
| opClass | input | 2 | Operation class: 0 single-cycle, 1 single-precision, 2 double-precision multiply, 3 as 0 |
| unitSel | input | 3 | Target functional unit |
| srcA | input | 5 | First source register (pair base for class 2) |
| srcB | input | 5 | Second source register (pair base for class 2) |
| dst | input | 5 | Destination register (pair base for class 2) |
| stall | output | 1 | Candidate must wait |
| dataHazard | output | 1 | A source register is still pending |
| resConflict | output | 1 | The target unit is still occupied |
| destBusy | output | 1 | The destination register is still pending |
| issueAck | output | 1 | Candidate is issued at the coming edge |

## Verification
The bench builds the block with its default parameters:
- 32 registers in two files of 16;
- 8 units;
- latencies of 3 and 9 delay slots;
- 4-cycle occupancy for the double-precision multiply.

With these values, the full 9-slot countdown and the 3-cycle unit hold can be walked cycle by cycle in one timeline. The same timeline reaches a unit reused while its own result is still pending, a hazard and a conflict reported together, and the pair halves reached through an odd index. The bench also covers a stalled operation that must leave no trace, and a reset applied while operations are in flight.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_CNT_W = 4;

  typedef enum logic [1:0] {
    OP_SINGLE = 2'd0,
    OP_SPFLT  = 2'd1,
    OP_DPMUL  = 2'd2,
    OP_ALT    = 2'd3
  } opClass_e;

  typedef struct packed {
    logic                issueEn;
    logic                pairMode;
    logic [SB_CNT_W-1:0] resultWait;
    logic [SB_CNT_W-1:0] unitHold;
  } sbStrobe_t;
endpackage

// File: rtl/sbControl.sv
module sbControl
  import sb_pkg::*;
#(
  parameter int SP_SLOTS = 3,
  parameter int DP_SLOTS = 9,
  parameter int DP_HOLD  = 4
) (
  input  logic      issueReq,
  input  opClass_e  opClass,
  input  logic      srcPend,
  input  logic      dstPend,
  input  logic      unitBusy,
  output sbStrobe_t strobe,
  output logic      stall,
  output logic      dataHazard,
  output logic      resConflict,
  output logic      destBusy,
  output logic      issueAck
);
  logic anyBlock;

  always_comb begin
    anyBlock    = srcPend | dstPend | unitBusy;
    dataHazard  = issueReq & srcPend;
    resConflict = issueReq & unitBusy;
    destBusy    = issueReq & dstPend;
    stall       = issueReq & anyBlock;
    issueAck    = issueReq & ~anyBlock;

    strobe.issueEn  = issueAck;
    strobe.pairMode = (opClass == OP_DPMUL);
    unique case (opClass)
      OP_SPFLT: begin
        strobe.resultWait = SB_CNT_W'(SP_SLOTS);
        strobe.unitHold   = '0;
      end
      OP_DPMUL: begin
        strobe.resultWait = SB_CNT_W'(DP_SLOTS);
        strobe.unitHold   = SB_CNT_W'(DP_HOLD - 1);
      end
      default: begin
        strobe.resultWait = '0;
        strobe.unitHold   = '0;
      end
    endcase
  end
endmodule

// File: rtl/sbDatapath.sv
module sbDatapath
  import sb_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter int NUM_UNITS = 8,
  parameter int UNIT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sbStrobe_t            strobe,
  input  logic [REG_IDX_W-1:0] srcA,
  input  logic [REG_IDX_W-1:0] srcB,
  input  logic [REG_IDX_W-1:0] dst,
  input  logic [UNIT_W-1:0]    unitSel,
  output logic                 srcPend,
  output logic                 dstPend,
  output logic                 unitBusy
);
  localparam int NUM_REGS = 2 ** REG_IDX_W;

  logic [SB_CNT_W-1:0] regCnt  [NUM_REGS];
  logic [SB_CNT_W-1:0] unitCnt [NUM_UNITS];
  logic [NUM_REGS-1:0]  pendVec;
  logic [NUM_UNITS-1:0] busyVec;
  logic [NUM_REGS-1:0]  maskA, maskB, maskD;

  function automatic logic [NUM_REGS-1:0] selMask(input logic [REG_IDX_W-1:0] idx,
                                                   input logic pair);
    logic [NUM_REGS-1:0] m;
    m = '0;
    if (pair) begin
      m[{idx[REG_IDX_W-1:1], 1'b0}] = 1'b1;
      m[{idx[REG_IDX_W-1:1], 1'b1}] = 1'b1;
    end else begin
      m[idx] = 1'b1;
    end
    return m;
  endfunction

  always_comb begin
    maskA    = selMask(srcA, strobe.pairMode);
    maskB    = selMask(srcB, strobe.pairMode);
    maskD    = selMask(dst, strobe.pairMode);
    srcPend  = |(pendVec & (maskA | maskB));
    dstPend  = |(pendVec & maskD);
    unitBusy = busyVec[unitSel];
  end

  // one result countdown per register
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    assign pendVec[g] = |regCnt[g];
    always_ff @(posedge clk) begin
      if (!rstN)
        regCnt[g] <= '0;
      else if (strobe.issueEn && maskD[g])
        regCnt[g] <= strobe.resultWait;
      else if (pendVec[g])
        regCnt[g] <= regCnt[g] - SB_CNT_W'(1);
    end
  end

  // one occupancy countdown per functional unit
  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    assign busyVec[u] = |unitCnt[u];
    always_ff @(posedge clk) begin
      if (!rstN)
        unitCnt[u] <= '0;
      else if (strobe.issueEn && unitSel == UNIT_W'(u))
        unitCnt[u] <= strobe.unitHold;
      else if (busyVec[u])
        unitCnt[u] <= unitCnt[u] - SB_CNT_W'(1);
    end
  end
endmodule

// File: rtl/sbScoreboard.sv
module sbScoreboard
  import sb_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter int NUM_UNITS = 8,
  parameter int SP_SLOTS  = 3,
  parameter int DP_SLOTS  = 9,
  parameter int DP_HOLD   = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             issueReq,
  input  logic [1:0]                       opClass,
  input  logic [$clog2(NUM_UNITS)-1:0]     unitSel,
  input  logic [REG_IDX_W-1:0]             srcA,
  input  logic [REG_IDX_W-1:0]             srcB,
  input  logic [REG_IDX_W-1:0]             dst,
  output logic                             stall,
  output logic                             dataHazard,
  output logic                             resConflict,
  output logic                             destBusy,
  output logic                             issueAck
);
  localparam int UNIT_W = $clog2(NUM_UNITS);

  sbStrobe_t strobe;
  logic srcPend, dstPend, unitBusy;

  sbControl #(
    .SP_SLOTS(SP_SLOTS), .DP_SLOTS(DP_SLOTS), .DP_HOLD(DP_HOLD)
  ) uCtl (
    .issueReq   (issueReq),
    .opClass    (opClass_e'(opClass)),
    .srcPend    (srcPend),
    .dstPend    (dstPend),
    .unitBusy   (unitBusy),
    .strobe     (strobe),
    .stall      (stall),
    .dataHazard (dataHazard),
    .resConflict(resConflict),
    .destBusy   (destBusy),
    .issueAck   (issueAck)
  );

  sbDatapath #(
    .REG_IDX_W(REG_IDX_W), .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcA    (srcA),
    .srcB    (srcB),
    .dst     (dst),
    .unitSel (unitSel),
    .srcPend (srcPend),
    .dstPend (dstPend),
    .unitBusy(unitBusy)
  );
endmodule

// File: rtl/sbScoreboard_chk.sv
module sbScoreboard_chk #(
  parameter int REG_IDX_W = 5,
  parameter int UNIT_W    = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueReq,
  input logic [1:0]           opClass,
  input logic [UNIT_W-1:0]    unitSel,
  input logic [REG_IDX_W-1:0] srcA,
  input logic [REG_IDX_W-1:0] srcB,
  input logic [REG_IDX_W-1:0] dst,
  input logic                 stall,
  input logic                 dataHazard,
  input logic                 resConflict,
  input logic                 destBusy,
  input logic                 issueAck
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !issueReq |-> !stall && !dataHazard && !resConflict && !destBusy && !issueAck);

  assert_ack_no_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    issueAck |-> !stall);

  assert_sp_result_hidden_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueAck && opClass == 2'd1) |=>
      (!(issueReq && opClass == 2'd0 && (srcA == $past(dst) || srcB == $past(dst))) || dataHazard));

  assert_sp_unit_reuse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueAck && opClass == 2'd1) |=>
      (!(issueReq && unitSel == $past(unitSel)) || !resConflict));

  assert_dp_unit_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issueAck && opClass == 2'd2) |=>
      (!(issueReq && unitSel == $past(unitSel)) || resConflict));

  assert_dp_pair_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (issueAck && opClass == 2'd2) |=>
      (!(issueReq && opClass == 2'd0 &&
         srcA == {$past(dst[REG_IDX_W-1:1]), 1'b1}) || dataHazard));
endmodule

bind sbScoreboard sbScoreboard_chk #(.REG_IDX_W(REG_IDX_W), .UNIT_W(UNIT_W)) uChk (.*);

// File: tb/sbScoreboard_test.sv
module sbScoreboard_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       issueReq = 1'b0;
  logic [1:0] opClass = 2'd0;
  logic [2:0] unitSel = 3'd0;
  logic [4:0] srcA = 5'd0, srcB = 5'd0, dst = 5'd0;
  logic       stall, dataHazard, resConflict, destBusy, issueAck;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sbScoreboard uut (
    .clk(clk), .rstN(rstN), .issueReq(issueReq), .opClass(opClass),
    .unitSel(unitSel), .srcA(srcA), .srcB(srcB), .dst(dst),
    .stall(stall), .dataHazard(dataHazard), .resConflict(resConflict),
    .destBusy(destBusy), .issueAck(issueAck)
  );

  // {reqTag[3:0], req, class[1:0], unit[2:0], srcA, srcB, dst, exp{stall,haz,conf,dstBusy}}
  localparam int NV = 25;
  localparam logic [28:0] VEC [NV] = '{
    {4'd3, 1'b1, 2'd1, 3'd2, 5'd1,  5'd2,  5'd3,  4'b0000}, // c0  R3 issue SP
    {4'd3, 1'b1, 2'd0, 3'd4, 5'd3,  5'd0,  5'd5,  4'b1100}, // c1  R3 slot 1
    {4'd3, 1'b1, 2'd0, 3'd4, 5'd3,  5'd0,  5'd5,  4'b1100}, // c2  R3 slot 2
    {4'd3, 1'b1, 2'd0, 3'd4, 5'd3,  5'd0,  5'd5,  4'b1100}, // c3  R3 slot 3
    {4'd3, 1'b1, 2'd0, 3'd4, 5'd3,  5'd0,  5'd5,  4'b0000}, // c4  R3 readable
    {4'd3, 1'b1, 2'd1, 3'd1, 5'd6,  5'd7,  5'd8,  4'b0000}, // c5  R3 SP on u1
    {4'd3, 1'b1, 2'd1, 3'd1, 5'd9,  5'd10, 5'd11, 4'b0000}, // c6  R3 u1 reused at once
    {4'd5, 1'b1, 2'd2, 3'd0, 5'd12, 5'd14, 5'd16, 4'b0000}, // c7  R5 issue DP
    {4'd4, 1'b1, 2'd2, 3'd0, 5'd20, 5'd22, 5'd24, 4'b1010}, // c8  R4 unit busy
    {4'd4, 1'b1, 2'd2, 3'd0, 5'd20, 5'd22, 5'd24, 4'b1010}, // c9  R4
    {4'd4, 1'b1, 2'd2, 3'd0, 5'd20, 5'd22, 5'd24, 4'b1010}, // c10 R4
    {4'd4, 1'b1, 2'd2, 3'd0, 5'd20, 5'd22, 5'd24, 4'b0000}, // c11 R4 unit free
    {4'd6, 1'b1, 2'd0, 3'd5, 5'd17, 5'd0,  5'd1,  4'b1100}, // c12 R6 odd half pending
    {4'd7, 1'b1, 2'd2, 3'd0, 5'd16, 5'd2,  5'd26, 4'b1110}, // c13 R7 hazard+conflict
    {4'd7, 1'b1, 2'd0, 3'd6, 5'd0,  5'd1,  5'd25, 4'b1001}, // c14 R7 dest only
    {4'd8, 1'b0, 2'd0, 3'd0, 5'd16, 5'd25, 5'd24, 4'b0000}, // c15 R8 no request
    {4'd5, 1'b1, 2'd2, 3'd1, 5'd16, 5'd0,  5'd28, 4'b1100}, // c16 R5 last slot
    {4'd5, 1'b1, 2'd2, 3'd1, 5'd16, 5'd0,  5'd28, 4'b0000}, // c17 R5 10 cycles later
    {4'd6, 1'b1, 2'd0, 3'd3, 5'd29, 5'd0,  5'd30, 4'b1100}, // c18 R6 pair half
    {4'd6, 1'b1, 2'd2, 3'd2, 5'd0,  5'd2,  5'd31, 4'b0000}, // c19 R6 odd dst index
    {4'd6, 1'b1, 2'd0, 3'd4, 5'd30, 5'd0,  5'd0,  4'b1100}, // c20 R6 even half pending
    {4'd2, 1'b1, 2'd3, 3'd2, 5'd0,  5'd2,  5'd5,  4'b1010}, // c21 R2 code 3 on busy unit
    {4'd9, 1'b1, 2'd0, 3'd4, 5'd26, 5'd27, 5'd0,  4'b0000}, // c22 R9 stalled DP left no trace
    {4'd2, 1'b1, 2'd3, 3'd2, 5'd0,  5'd2,  5'd6,  4'b0000}, // c23 R2 code 3 issues
    {4'd2, 1'b1, 2'd0, 3'd7, 5'd6,  5'd0,  5'd7,  4'b0000}  // c24 R2 zero delay
  };

  task automatic apply(input logic req, input logic [1:0] cls, input logic [2:0] u,
                       input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    issueReq = req; opClass = cls; unitSel = u; srcA = a; srcB = b; dst = d;
  endtask

  task automatic check(input int tag, input logic [3:0] exp, input int idx);
    logic [4:0] act, want;
    #1;
    act  = {stall, dataHazard, resConflict, destBusy, issueAck};
    want = {exp, issueReq & ~exp[3]};
    total++;
    if (act !== want) begin
      bad++;
      $display("FAIL R%0d step %0d: got %b expected %b", tag, idx, act, want);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 / R8: clean state, no request
    apply(1'b0, 2'd2, 3'd0, 5'd0, 5'd0, 5'd2);
    check(8, 4'b0000, -1);
    apply(1'b1, 2'd2, 3'd0, 5'd0, 5'd0, 5'd2);
    check(1, 4'b0000, -2);              // R1 reset state: nothing pending
    @(negedge clk);
    apply(1'b0, 2'd0, 3'd0, 5'd0, 5'd0, 5'd0);
    repeat (12) @(negedge clk);          // let the DP from the reset check drain
    for (int i = 0; i < NV; i++) begin
      if (i > 0) @(negedge clk);
      apply(VEC[i][24], VEC[i][23:22], VEC[i][21:19], VEC[i][18:14], VEC[i][13:9], VEC[i][8:4]);
      check(int'(VEC[i][28:25]), VEC[i][3:0], i);
    end

    // R9: absent request must not load state
    @(negedge clk);
    apply(1'b0, 2'd2, 3'd3, 5'd0, 5'd0, 5'd10);
    check(9, 4'b0000, 100);
    @(negedge clk);
    apply(1'b1, 2'd0, 3'd3, 5'd10, 5'd0, 5'd0);
    check(9, 4'b0000, 101);              // R9 r10 and u3 untouched

    // R1: reset while operations are in flight
    @(negedge clk);
    apply(1'b1, 2'd2, 3'd3, 5'd0, 5'd0, 5'd12);
    check(1, 4'b0000, 102);
    @(negedge clk);
    rstN = 1'b0;
    apply(1'b0, 2'd0, 3'd0, 5'd0, 5'd0, 5'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    apply(1'b1, 2'd0, 3'd3, 5'd13, 5'd12, 5'd1);
    check(1, 4'b0000, 103);              // R1 pending pair cleared
    @(negedge clk);
    apply(1'b1, 2'd2, 3'd3, 5'd4, 5'd6, 5'd8);
    check(1, 4'b0000, 104);              // R1 unit u3 not occupied (SC just before)

    @(negedge clk);
    apply(1'b0, 2'd0, 3'd0, 5'd0, 5'd0, 5'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule